// File: doc/BRIEF.md
# Clock Frequency Offset Monitor

This block judges how far each of several monitored clocks runs from a reference clock. One configuration bit picks the reference: a free-running master clock or the recovered clock of the timing loop. Over a window of a fixed number of reference periods, every channel counts the rising edges of its own clock. At the window end it turns the excess or shortfall against the window length into a signed 8-bit offset code. All clocks are sampled by one fast system clock through two-flop synchronizers and edge detectors, so the counting runs in a single clock domain.

A shared 4-bit scale factor gives the size of one code step in ppm. The alarm limit is a 4-bit field plus one, counted in the same steps. The limit is therefore (field + 1) × scale ppm and the reading is code × scale ppm. The scale cancels in the comparison, and changing the factor rescales the reading and the alarm together. Each channel has its own alarm flag and a disqualify flag for reference selection. A 4-bit read select puts one channel's code, and its ppm product, on a read port.

Top module: `freq_offset_mon`

## Requirements
- R1: With `ref_sel_i` = 0 the window counts rising edges of `mst_ref_i`; with 1 it counts rising edges of `loop_ref_i`. A window spans `WIN_REFS` (default 32) rising edges of the chosen reference.
- R2: A channel's code is the number of rising edges of its clock within one window minus `WIN_REFS`, as an 8-bit two's-complement value.
- R3: A difference above +127 gives code +127, and one below -127 gives -127.
- R4: A channel whose clock has no rising edge during a window gives code 0x80 (-128). For alarm purposes this code has magnitude 128.
- R5: `rd_sel_i` values 0 to `NUM_IN`-1 put that channel's code on `rd_code_o`. Any larger value gives 0.
- R6: `rd_ppm_o` is `rd_code_o` (signed) times `scale_i` (unsigned), as a 12-bit two's-complement value.
- R7: With `alm_en_i` = 1 at a window end, a channel's alarm is set when its new code's magnitude exceeds `alm_thr_i` + 1.
- R8: With `alm_en_i` = 1, the alarm is cleared when the magnitude is below `alm_thr_i` + 1. When the magnitude equals it, the alarm keeps its state.
- R9: With `alm_en_i` = 0 at a window end, every alarm is cleared, whatever the offsets.
- R10: `disq_o` bit n equals `alarm_o` bit n at all times.
- R11: Codes and alarms reset to 0. They change only in the cycle after a window end and hold between window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, faster than twice every monitored clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_ref_i | input | 1 | Free-running master reference clock |
| loop_ref_i | input | 1 | Recovered loop reference clock |
| ref_sel_i | input | 1 | Reference choice: 0 master, 1 loop |
| mon_clk_i | input | NUM_IN | Monitored clocks, one per channel |
| alm_en_i | input | 1 | Hard-alarm enable |
| alm_thr_i | input | 4 | Alarm limit field; limit is this value plus one, in code steps |
| scale_i | input | 4 | ppm per code step |
| rd_sel_i | input | 4 | Channel shown on the read port |
| rd_code_o | output | 8 | Selected channel's offset code |
| rd_ppm_o | output | 12 | Selected code times the scale |
| alarm_o | output | NUM_IN | Per-channel hard-alarm flags |
| disq_o | output | NUM_IN | Per-channel disqualify flags |

## Verification
A change of the read select can land in the same cycle as the window-end update of the code it reads. The bench holds each monitored clock at a steady rate and switches `rd_sel_i` every cycle for several hundred cycles, which crosses many window ends at arbitrary phases. Every sample must equal the settled code of the selected channel; a torn or partial value counts as a failure. The alarm-limit equality case is judged the same way: each outcome depends on the flag's previous state at a boundary.

// File: rtl/fom_pkg.sv
`timescale 1ns/1ps
// fom_pkg: shared code type and helpers for the frequency offset monitor.
// Assumes 8-bit two's-complement offset codes; -128 is reserved for "no edges".
package fom_pkg;
    typedef logic signed [7:0] code_t;

    localparam code_t DEAD_CODE = 8'sh80;

    // Clamp a signed edge-count difference into the -127..+127 code range.
    function automatic code_t clamp_code(input int diff);
        if (diff > 127)
            return 8'sd127;
        else if (diff < -127)
            return -8'sd127;
        else
            return code_t'(diff[7:0]);
    endfunction

    // Magnitude of a code, with the reserved dead code mapping to 128.
    function automatic logic [7:0] code_mag(input code_t c);
        if (c == DEAD_CODE)
            return 8'd128;
        else if (c[7])
            return 8'(-c);
        else
            return 8'(c);
    endfunction
endpackage

// File: rtl/fom_edge_sync.sv
`timescale 1ns/1ps
// fom_edge_sync: brings an asynchronous clock-like signal into clk through
// STAGES flops and emits a one-cycle pulse per rising edge.
// Assumes the signal stays high and low for at least one clk period each.
module fom_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] pipe_q;

    // Shift the sampled level through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pipe_q <= '0;
        else
            pipe_q <= {pipe_q[STAGES-1:0], async_i};
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/fom_window.sv
`timescale 1ns/1ps
// fom_window: picks the reference edge stream and flags the last edge of
// each window of WIN_REFS reference edges.
// Assumes both edge inputs are single-cycle pulses in the clk domain.
module fom_window #(
    parameter int WIN_REFS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_sel_i,
    input  logic mst_rise_i,
    input  logic loop_rise_i,
    output logic win_end_o
);
    localparam int WC_W = (WIN_REFS > 1) ? $clog2(WIN_REFS) : 1;

    logic            ref_rise;
    logic [WC_W-1:0] rcnt_q;

    assign ref_rise  = ref_sel_i ? loop_rise_i : mst_rise_i;
    assign win_end_o = ref_rise && (rcnt_q == WC_W'(WIN_REFS - 1));

    // Count reference edges; wrap at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rcnt_q <= '0;
        else if (win_end_o)
            rcnt_q <= '0;
        else if (ref_rise)
            rcnt_q <= rcnt_q + 1'b1;
    end
endmodule

// File: rtl/fom_chan.sv
`timescale 1ns/1ps
// fom_chan: one monitored channel. Counts clock edges over a window, turns
// the count into a clamped offset code and updates its hard alarm at the end.
// Assumes win_end_i is a one-cycle pulse; edges on that cycle open the next window.
module fom_chan
    import fom_pkg::*;
#(
    parameter int WIN_REFS = 32,
    parameter int CNT_W    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       edge_i,
    input  logic       win_end_i,
    input  logic       alm_en_i,
    input  logic [3:0] thr_i,
    output code_t      code_o,
    output logic       alarm_o
);
    logic [CNT_W-1:0] ecnt_q;
    code_t            code_q;
    code_t            code_nx;
    logic             alarm_q;
    logic [7:0]       mag;
    logic [7:0]       lim;

    // Form the code the current window would produce.
    always_comb begin
        if (ecnt_q == '0)
            code_nx = DEAD_CODE;
        else
            code_nx = clamp_code(int'(ecnt_q) - WIN_REFS);
    end

    assign mag = code_mag(code_nx);
    assign lim = 8'(thr_i) + 8'd1;

    // Count input edges, restarting at each window end, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ecnt_q <= '0;
        else if (win_end_i)
            ecnt_q <= edge_i ? CNT_W'(1) : '0;
        else if (edge_i && (ecnt_q != '1))
            ecnt_q <= ecnt_q + 1'b1;
    end

    // Capture the code and update the alarm only at window ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            alarm_q <= 1'b0;
        end else if (win_end_i) begin
            code_q <= code_nx;
            if (!alm_en_i)
                alarm_q <= 1'b0;
            else if (mag > lim)
                alarm_q <= 1'b1;
            else if (mag < lim)
                alarm_q <= 1'b0;
        end
    end

    assign code_o  = code_q;
    assign alarm_o = alarm_q;
endmodule

// File: rtl/freq_offset_mon.sv
`timescale 1ns/1ps
// freq_offset_mon: frequency offset monitor for NUM_IN clocks against a
// selectable reference, with per-channel hard alarms and a read port.
// Assumes clk samples every reference and monitored clock at least twice per period.
module freq_offset_mon
    import fom_pkg::*;
#(
    parameter int NUM_IN   = 5,
    parameter int WIN_REFS = 32,
    parameter int CNT_W    = 16,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mst_ref_i,
    input  logic              loop_ref_i,
    input  logic              ref_sel_i,
    input  logic [NUM_IN-1:0] mon_clk_i,
    input  logic              alm_en_i,
    input  logic [3:0]        alm_thr_i,
    input  logic [3:0]        scale_i,
    input  logic [3:0]        rd_sel_i,
    output logic [7:0]        rd_code_o,
    output logic [11:0]       rd_ppm_o,
    output logic [NUM_IN-1:0] alarm_o,
    output logic [NUM_IN-1:0] disq_o
);
    logic              mst_rise;
    logic              loop_rise;
    logic              win_end;
    logic [NUM_IN-1:0] mon_rise;
    code_t             codes [NUM_IN];
    code_t             rd_code;
    logic signed [12:0] prod;

    fom_edge_sync #(.STAGES(SYNC_STG)) u_sync_mst (
        .clk(clk), .rst_n(rst_n), .async_i(mst_ref_i), .rise_o(mst_rise)
    );

    fom_edge_sync #(.STAGES(SYNC_STG)) u_sync_loop (
        .clk(clk), .rst_n(rst_n), .async_i(loop_ref_i), .rise_o(loop_rise)
    );

    fom_window #(.WIN_REFS(WIN_REFS)) u_win (
        .clk(clk), .rst_n(rst_n), .ref_sel_i(ref_sel_i),
        .mst_rise_i(mst_rise), .loop_rise_i(loop_rise), .win_end_o(win_end)
    );

    for (genvar g = 0; g < NUM_IN; g++) begin : g_ch
        fom_edge_sync #(.STAGES(SYNC_STG)) u_sync (
            .clk(clk), .rst_n(rst_n), .async_i(mon_clk_i[g]), .rise_o(mon_rise[g])
        );

        fom_chan #(.WIN_REFS(WIN_REFS), .CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .edge_i(mon_rise[g]), .win_end_i(win_end),
            .alm_en_i(alm_en_i), .thr_i(alm_thr_i),
            .code_o(codes[g]), .alarm_o(alarm_o[g])
        );
    end

    // Read mux: selected channel code, zero for unused select values.
    always_comb begin
        rd_code = '0;
        for (int i = 0; i < NUM_IN; i++)
            if (int'(rd_sel_i) == i)
                rd_code = codes[i];
    end

    assign prod      = rd_code * $signed({1'b0, scale_i});
    assign rd_code_o = rd_code;
    assign rd_ppm_o  = prod[11:0];
    assign disq_o    = alarm_o;
endmodule

// File: rtl/fom_checker.sv
`timescale 1ns/1ps
// fom_checker: timing properties of the offset monitor, bound to the top.
module fom_checker #(
    parameter int NUM_IN = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              win_end,
    input logic              alm_en,
    input logic [3:0]        rd_sel,
    input logic [7:0]        rd_code,
    input logic [NUM_IN-1:0] alarm
);
    AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(alarm)); // R11

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> (!$stable(rd_sel) || $stable(rd_code))); // R11

    AST_ALARM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && !alm_en) |=> (alarm == '0)); // R9

    AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_sel) >= NUM_IN) |-> (rd_code == 8'h00)); // R5

    AST_WIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> !win_end); // R1
endmodule

bind freq_offset_mon fom_checker #(.NUM_IN(NUM_IN)) u_chk (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .alm_en(alm_en_i),
    .rd_sel(rd_sel_i), .rd_code(rd_code_o), .alarm(alarm_o)
);

// File: tb/sim_freq_offset_mon.sv
`timescale 1ns/1ps
// Bench for freq_offset_mon: vector table, then directed corner cases.
module sim_freq_offset_mon;
    localparam int N      = 5;
    localparam int MST_P  = 6;   // master ref period in clk cycles: window 192
    localparam int LOOP_P = 12;  // loop ref period in clk cycles: window 384
    localparam int SETTLE = 1300;
    localparam int NV     = 5;

    // refsel, en, thr, scale, p0..p4, c0..c4, alarm mask
    localparam int VT [NV][15] = '{
        '{0, 1,  7, 1,  6, 4, 16, 12,  0,     0, 16, -20, -16, -128, 30},
        '{1, 1, 15, 5, 12, 4,  6,  2, 16,     0, 64,  32, 127,   -8, 14},
        '{1, 0,  0, 15, 0, 2,  4,  8, 16,  -128, 127, 64,  16,   -8,  0},
        '{0, 1,  0, 0,  6, 6,  6,  6,  8,     0,  0,   0,   0,   -8, 16},
        '{0, 1,  3, 9,  3, 2, 24, 64,  4,    32, 64, -24, -29,   16, 31}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mst_ref = 1'b0;
    logic         loop_ref = 1'b0;
    logic         ref_sel = 1'b0;
    logic [N-1:0] mon_clk = '0;
    logic         alm_en = 1'b0;
    logic [3:0]   alm_thr = '0;
    logic [3:0]   scale = '0;
    logic [3:0]   rd_sel = '0;
    logic [7:0]   rd_code;
    logic [11:0]  rd_ppm;
    logic [N-1:0] alarm;
    logic [N-1:0] disq;

    int per [N];
    int pc [N];
    int mc = 0;
    int lc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    freq_offset_mon u0 (
        .clk(clk), .rst_n(rst_n), .mst_ref_i(mst_ref), .loop_ref_i(loop_ref),
        .ref_sel_i(ref_sel), .mon_clk_i(mon_clk), .alm_en_i(alm_en),
        .alm_thr_i(alm_thr), .scale_i(scale), .rd_sel_i(rd_sel),
        .rd_code_o(rd_code), .rd_ppm_o(rd_ppm), .alarm_o(alarm), .disq_o(disq)
    );

    always #2.5 clk = ~clk;

    // Clock generators, stepped on the falling edge away from sampling.
    always @(negedge clk) begin
        mc <= (mc + 1) % MST_P;
        lc <= (lc + 1) % LOOP_P;
        mst_ref  <= ((mc + 1) % MST_P) < MST_P / 2;
        loop_ref <= ((lc + 1) % LOOP_P) < LOOP_P / 2;
        for (int i = 0; i < N; i++) begin
            if (per[i] == 0) begin
                pc[i] <= 0;
                mon_clk[i] <= 1'b0;
            end else begin
                pc[i] <= (pc[i] + 1) % per[i];
                mon_clk[i] <= ((pc[i] + 1) % per[i]) < per[i] / 2;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_ch(input int ch, output int code, output int ppm);
        rd_sel = 4'(ch);
        #1;
        code = int'($signed(rd_code));
        ppm  = int'($signed(rd_ppm));
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin per[i] = 0; pc[i] = 0; end
        #2000000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int code;
        int ppm;
        wait_cyc(5);
        // Reset state (R11)
        read_ch(0, code, ppm);
        chk("R11 reset code", code, 0);
        chk("R11 reset alarm", int'(alarm), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table (R1 R2 R3 R4 R6 R7 R9 R10)
        for (int v = 0; v < NV; v++) begin
            ref_sel = VT[v][0][0];
            alm_en  = VT[v][1][0];
            alm_thr = 4'(VT[v][2]);
            scale   = 4'(VT[v][3]);
            for (int i = 0; i < N; i++) per[i] = VT[v][4 + i];
            wait_cyc(SETTLE);
            for (int i = 0; i < N; i++) begin
                read_ch(i, code, ppm);
                chk($sformatf("R2 vec%0d ch%0d code", v, i), code, VT[v][9 + i]);
                chk($sformatf("R6 vec%0d ch%0d ppm", v, i), ppm, VT[v][9 + i] * VT[v][3]);
                @(negedge clk);
            end
            chk($sformatf("R7 vec%0d alarms", v), int'(alarm), VT[v][14]);
            chk($sformatf("R10 vec%0d disq", v), int'(disq), VT[v][14]);
        end

        // Read select beyond channel count (R5)
        read_ch(5, code, ppm);
        chk("R5 sel 5", code, 0);
        read_ch(15, code, ppm);
        chk("R5 sel 15", code, 0);

        // Select sweep across window ends: no torn values (R11)
        begin
            int bad = 0;
            for (int k = 0; k < 900; k++) begin
                @(negedge clk);
                read_ch(k % N, code, ppm);
                if (code != VT[NV-1][9 + (k % N)]) bad++;
            end
            chk("R11 sweep mismatches", bad, 0);
        end

        // Equal-limit hold and clear (R8): master ref, ch0 at +16
        ref_sel = 1'b0; alm_en = 1'b1; scale = 4'd1; alm_thr = 4'd3;
        per[0] = 4;
        wait_cyc(SETTLE);
        chk("R7 ch0 set", int'(alarm[0]), 1);
        alm_thr = 4'd15;
        wait_cyc(SETTLE);
        chk("R8 ch0 equal holds set", int'(alarm[0]), 1);
        per[0] = 6;
        wait_cyc(SETTLE);
        chk("R8 ch0 cleared", int'(alarm[0]), 0);
        per[0] = 4;
        wait_cyc(SETTLE);
        chk("R8 ch0 equal holds clear", int'(alarm[0]), 0);
        alm_thr = 4'd14;
        wait_cyc(SETTLE);
        chk("R7 ch0 just above limit", int'(alarm[0]), 1);

        // Dead channel alarms when enabled, not when disabled (R4 R9)
        per[2] = 0;
        wait_cyc(SETTLE);
        read_ch(2, code, ppm);
        chk("R4 dead code", code, -128);
        chk("R4 dead alarm", int'(alarm[2]), 1);
        alm_en = 1'b0;
        wait_cyc(SETTLE);
        chk("R9 disabled alarms", int'(alarm), 0);

        // Reset mid-run clears state (R11)
        rst_n = 1'b0;
        wait_cyc(3);
        read_ch(2, code, ppm);
        chk("R11 reset code again", code, 0);
        rst_n = 1'b1;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule